// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two WIDTH-bit operands over WIDTH clock cycles, one recoding step per cycle. A start pulse captures the multiplicand into a one-bit-wider register and the multiplier into the low half of a combined product/multiplier register. That combined register also holds a left extension bit and a right guard bit. Every cycle the block adds a selected multiple of the multiplicand to the upper half and then shifts the whole register right by one place.

The mode input is sampled together with the start pulse. In two's-complement mode the step examines the lowest multiplier bit together with the guard bit to its right. The pair 01 adds the multiplicand, 10 subtracts it, and 00 or 11 adds nothing. The shift is arithmetic. In unsigned mode the step adds the multiplicand when the lowest multiplier bit is 1, and the shift brings a zero in at the top. When the last step is done, the extension and guard bits are dropped and the 2*WIDTH-bit result appears on the product output.

Top module: `booth_mul`

## Requirements
- R1: After reset, busy, done and product are all 0.
- R2: With signed_mode=0 at start, the product equals the unsigned product of a and b, both read as unsigned integers from 0 to 2^WIDTH-1.
- R3: With signed_mode=1 at start, the product equals the two's-complement product of a and b, sign-extended to 2*WIDTH bits.
- R4: In signed mode the most negative operand value (only the top bit set) gives the correct result on either input or on both inputs.
- R5: busy rises on the clock edge that samples start. It stays high for exactly WIDTH cycles. done is high during the first cycle after busy falls.
- R6: done is high for exactly one cycle for each accepted start.
- R7: While idle with start low, the product output holds its value.
- R8: A start pulse that arrives while busy is high is ignored. Its operands and mode do not affect the running result or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (ignored while busy) |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned operands |
| a | input | WIDTH | Multiplicand |
| b | input | WIDTH | Multiplier |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Result |

## Verification
The operand patterns are chosen so that each one exposes a different fault. Zero, one and all-ones multipliers separate a wrong add-or-skip decision from a wrong shift. Alternating bit patterns make each signed step go through every Booth pair, so a swap of add and subtract shows up. Mixed-sign cases and cases with the most negative value on one or both inputs expose a missing extension bit or a logical shift used where an arithmetic shift belongs. The same bit patterns are also run in unsigned mode to show that the mode was captured at start. A second start during a running multiplication, with different operands and a different mode, checks that both the result and the timing come from the first request.

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               signed_mode,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);
  localparam logic [WIDTH:0] ONE = 1;

  logic [WIDTH:0]     mcand;
  logic [2*WIDTH+1:0] pm;
  logic [CW-1:0]      cnt;
  logic               mode_q;
  logic [WIDTH:0]     hi, addend, sum;
  logic [2*WIDTH+1:0] pm_next;

  assign hi = pm[2*WIDTH+1:WIDTH+1];

  always_comb begin
    addend = '0;
    if (mode_q) begin
      case (pm[1:0])
        2'b01:   addend = mcand;
        2'b10:   addend = ~mcand + ONE;
        default: addend = '0;
      endcase
    end else if (pm[1]) begin
      addend = mcand;
    end
  end

  assign sum     = hi + addend;
  assign pm_next = {mode_q & sum[WIDTH], sum, pm[WIDTH:1]};
  assign product = pm[2*WIDTH:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand  <= '0;
      pm     <= '0;
      cnt    <= '0;
      mode_q <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        pm  <= pm_next;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        mcand  <= {signed_mode & a[WIDTH-1], a};
        pm     <= {{(WIDTH+1){1'b0}}, b, 1'b0};
        mode_q <= signed_mode;
        cnt    <= '0;
        busy   <= 1'b1;
      end
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_busy_from_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
  p_ignore_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mcand) && $stable(mode_q));
  p_step_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CW'(WIDTH));
endmodule

// File: tb/booth_mul_tb.sv
module booth_mul_tb;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, start = 0, signed_mode = 0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, done;
  logic [2*W-1:0] product;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  booth_mul #(.WIDTH(W)) u_dut (.clk, .rst_n, .start, .signed_mode, .a, .b,
    .busy, .done, .product);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] expect_of(logic [W-1:0] x, logic [W-1:0] y, bit s);
    if (s) return 16'($signed(x) * $signed(y));
    return 16'(x) * 16'(y);
  endfunction

  task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input bit s,
                     input string req, input bit poke);
    int k;
    @(negedge clk);
    a = x; b = y; signed_mode = s; start = 1;
    @(negedge clk);
    start = 0;
    chk({req, " busy after start R5"}, busy, 1);
    k = 0;
    while (!done && k < 3*W) begin
      if (poke && k == 2) begin
        a = ~x; b = ~y; signed_mode = !s; start = 1;
      end
      @(negedge clk);
      start = 0;
      k++;
    end
    chk({req, " latency R5"}, k, W);
    chk({req, " busy low at done R5"}, busy, 0);
    chk({req, " product"}, product, expect_of(x, y, s));
    @(negedge clk);
    chk({req, " done single cycle R6"}, done, 0);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 product", product, 0);
  endtask

  task automatic t_unsigned;
    run(8'd0, 8'd77, 0, "R2 zero", 0);
    run(8'd1, 8'd255, 0, "R2 one", 0);
    run(8'd255, 8'd255, 0, "R2 max", 0);
    run(8'hAA, 8'h55, 0, "R2 alt", 0);
    run(8'd200, 8'd3, 0, "R2 mixed", 0);
  endtask

  task automatic t_signed;
    run(8'd5, 8'd7, 1, "R3 pos", 0);
    run(8'hFD, 8'd7, 1, "R3 negpos", 0);
    run(8'hFD, 8'hF9, 1, "R3 negneg", 0);
    run(8'hAA, 8'h55, 1, "R3 alt", 0);
    run(8'h55, 8'hAA, 1, "R3 alt2", 0);
    run(8'hFF, 8'hFF, 1, "R3 minus1", 0);
  endtask

  task automatic t_extreme;
    run(8'h80, 8'h80, 1, "R4 minmin", 0);
    run(8'h80, 8'h7F, 1, "R4 minmax", 0);
    run(8'h7F, 8'h80, 1, "R4 maxmin", 0);
    run(8'h80, 8'h01, 1, "R4 minone", 0);
  endtask

  task automatic t_hold;
    logic [2*W-1:0] keep;
    keep = product;
    repeat (5) @(negedge clk);
    chk("R7 hold", product, keep);
    chk("R7 idle", busy, 0);
  endtask

  task automatic t_ignore;
    run(8'h93, 8'h2C, 1, "R8 busy start signed", 1);
    run(8'hC8, 8'h0B, 0, "R8 busy start unsigned", 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_unsigned();
    t_signed();
    t_extreme();
    t_hold();
    t_ignore();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule